// File: doc/BRIEF.md
# Parallel QPP Interleaver Address Generator

This block produces the permuted addresses of a quadratic permutation polynomial interleaver for a turbo decoder that works on eight sub-blocks at once. A start strobe loads the block length K and the two polynomial coefficients f1 and f2. The block then spends a fixed number of setup cycles working out a starting point for each lane. After that it streams K/8 beats, and each beat carries one address per lane. Lane j on beat t gives pi(j*K/8 + t) = (f1*i + f2*i*i) mod K.

Every reduction modulo K is an addition followed by one compare and one conditional subtract. There is no divider and no stored table. During setup, each lane forms its seed address and seed increment by double-and-add multiplication modulo K, stepping over the bits of its start index, most significant bit first. While streaming, each lane advances on its own using two modular adds per beat. No lane uses any value from another lane.

A controller moves through five states:
- ST_IDLE goes to ST_PASS1 when start is accepted.
- ST_PASS1 goes to ST_PASS2 when its bit counter reaches zero, after KW cycles.
- ST_PASS2 goes to ST_SEED after another KW cycles.
- ST_SEED goes to ST_RUN after one cycle.
- ST_RUN goes back to ST_IDLE on the last beat.

Top module: `qpp_addr_gen`

## Requirements
- R1: After reset, valid_o and done_o are low.
- R2: On beat t of a run (t = 0 for the first valid beat), lane j gives (f1*i + f2*i*i) mod K with i = j*(K/8) + t. Lane j's address sits in addr_o bits [j*13 +: 13].
- R3: With K=40, f1=3, f2=10, lane 0 gives 0, 13, 6, 19, 12 on beats 0 to 4.
- R4: valid_o is high for exactly K/8 consecutive beats per run. done_o is high only together with the last of these beats, and valid_o is low in the cycle after done_o.
- R5: A start pulse is ignored while a run is busy, from the cycle after acceptance through the last beat. The addresses then stay those of the first run.
- R6: Every address given while valid_o is high is below the latched K.
- R7: The first valid beat follows the rising edge that samples start by exactly 2*13+1 further rising edges. It appears after the 28th edge, counting the sampling edge as the first.
- R8: Any K that is a multiple of 8, from 40 to 6144, is handled, up to the largest size with K/8 = 768 beats. Valid runs include 48, 256, 1024 and 6144.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| k_i | input | 13 | Block length K, a multiple of 8 |
| f1_i | input | 13 | Linear coefficient, below K |
| f2_i | input | 13 | Quadratic coefficient, below K |
| valid_o | output | 1 | Beat carries eight addresses |
| done_o | output | 1 | Last beat of the run |
| addr_o | output | 104 | Eight lane addresses, lane j at [j*13 +: 13] |

## Verification
The bench checks the literal five-address sequence for K=40. It also covers the largest length, where the sums reach 2K-2 and a missing or off-by-one conditional subtract would give addresses above K. Start pulses are injected both during the multiply passes and mid-stream: a design that accepted them would reload K and reseed, so the streamed addresses would stop matching the first run's schedule. The bench also checks the exact setup latency and that done_o falls on the last beat only. A bit-order or lane-offset error would show up as wrong seeds in every lane except lane 0.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PASS1 = 3'd1,
        ST_PASS2 = 3'd2,
        ST_SEED  = 3'd3,
        ST_RUN   = 3'd4
    } qpp_state_t;
endpackage

// File: rtl/qpp_ctrl.sv
module qpp_ctrl #(
    parameter int KW = 13,
    localparam int BW = $clog2(KW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [KW-1:0] beats_i,
    output logic          accept_o,
    output logic          pass1_o,
    output logic          pass2_o,
    output logic          seed_o,
    output logic          run_o,
    output logic          last_o,
    output logic [BW-1:0] bit_o
);
    import qpp_pkg::*;

    localparam logic [BW-1:0] TOP_BIT = BW'(KW - 1);

    qpp_state_t    state_q, state_d;
    logic [BW-1:0] bit_q;
    logic [KW-1:0] beat_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)           state_d = ST_PASS1;
            ST_PASS1: if (bit_q == '0)       state_d = ST_PASS2;
            ST_PASS2: if (bit_q == '0)       state_d = ST_SEED;
            ST_SEED:                         state_d = ST_RUN;
            ST_RUN:   if (beat_q == beats_i - 1'b1) state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    bit_q  <= TOP_BIT;
                    beat_q <= '0;
                end
                ST_PASS1: bit_q <= (bit_q == '0) ? TOP_BIT : bit_q - 1'b1;
                ST_PASS2: bit_q <= (bit_q == '0) ? '0 : bit_q - 1'b1;
                ST_SEED:  beat_q <= '0;
                ST_RUN:   beat_q <= beat_q + 1'b1;
                default:  bit_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        accept_o = 1'b0;
        pass1_o  = 1'b0;
        pass2_o  = 1'b0;
        seed_o   = 1'b0;
        run_o    = 1'b0;
        last_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept_o = start_i;
            ST_PASS1: pass1_o  = 1'b1;
            ST_PASS2: pass2_o  = 1'b1;
            ST_SEED:  seed_o   = 1'b1;
            ST_RUN: begin
                run_o  = 1'b1;
                last_o = (beat_q == beats_i - 1'b1);
            end
            default: ;
        endcase
    end

    assign bit_o = bit_q;
endmodule

// File: rtl/qpp_lane.sv
module qpp_lane #(
    parameter int KW = 13,
    localparam int BW = $clog2(KW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          pass1_i,
    input  logic          pass2_i,
    input  logic          seed_i,
    input  logic          step_i,
    input  logic [BW-1:0] bit_i,
    input  logic [KW-1:0] k_i,
    input  logic [KW-1:0] f1_i,
    input  logic [KW-1:0] f2_i,
    input  logic [KW-1:0] s_i,
    output logic [KW-1:0] addr_o
);
    // (a + b) mod k for a, b < k: one add, one compare, one subtract
    function automatic logic [KW-1:0] madd(input logic [KW-1:0] a,
                                           input logic [KW-1:0] b,
                                           input logic [KW-1:0] k);
        logic [KW:0] sum;
        logic [KW:0] red;
        sum = {1'b0, a} + {1'b0, b};
        red = sum - {1'b0, k};
        return (sum >= {1'b0, k}) ? red[KW-1:0] : sum[KW-1:0];
    endfunction

    // one double-and-add step of a modular multiply
    function automatic logic [KW-1:0] hstep(input logic [KW-1:0] acc,
                                            input logic [KW-1:0] add,
                                            input logic [KW-1:0] k);
        return madd(madd(acc, acc, k), add, k);
    endfunction

    logic [KW-1:0] acc_lin;   // f1*s
    logic [KW-1:0] acc_sq;    // s*s
    logic [KW-1:0] acc_f2s;   // f2*s
    logic [KW-1:0] acc_quad;  // f2*s*s
    logic [KW-1:0] pi_q;
    logic [KW-1:0] inc_q;
    logic [KW-1:0] inc_step;
    logic          sbit;
    logic          qbit;

    assign inc_step = madd(f2_i, f2_i, k_i);
    assign sbit     = s_i[bit_i];
    assign qbit     = acc_sq[bit_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_lin  <= '0;
            acc_sq   <= '0;
            acc_f2s  <= '0;
            acc_quad <= '0;
            pi_q     <= '0;
            inc_q    <= '0;
        end else if (clr_i) begin
            acc_lin  <= '0;
            acc_sq   <= '0;
            acc_f2s  <= '0;
            acc_quad <= '0;
        end else if (pass1_i) begin
            acc_lin <= hstep(acc_lin, sbit ? f1_i : '0, k_i);
            acc_sq  <= hstep(acc_sq,  sbit ? s_i  : '0, k_i);
            acc_f2s <= hstep(acc_f2s, sbit ? f2_i : '0, k_i);
        end else if (pass2_i) begin
            acc_quad <= hstep(acc_quad, qbit ? f2_i : '0, k_i);
        end else if (seed_i) begin
            pi_q  <= madd(acc_lin, acc_quad, k_i);
            inc_q <= madd(madd(f1_i, f2_i, k_i), madd(acc_f2s, acc_f2s, k_i), k_i);
        end else if (step_i) begin
            pi_q  <= madd(pi_q, inc_q, k_i);
            inc_q <= madd(inc_q, inc_step, k_i);
        end
    end

    assign addr_o = pi_q;
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen #(
    parameter int LANES = 8,
    parameter int KW    = 13,
    localparam int LSH  = $clog2(LANES),
    localparam int BW   = $clog2(KW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [KW-1:0]       k_i,
    input  logic [KW-1:0]       f1_i,
    input  logic [KW-1:0]       f2_i,
    output logic                valid_o,
    output logic                done_o,
    output logic [LANES*KW-1:0] addr_o
);
    logic [KW-1:0] k_q, f1_q, f2_q;
    logic [KW-1:0] beats;
    logic          accept, pass1, pass2, seed, run, last;
    logic [BW-1:0] bitsel;

    assign beats = k_q >> LSH;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q  <= '0;
            f1_q <= '0;
            f2_q <= '0;
        end else if (accept) begin
            k_q  <= k_i;
            f1_q <= f1_i;
            f2_q <= f2_i;
        end
    end

    qpp_ctrl #(.KW(KW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .beats_i  (beats),
        .accept_o (accept),
        .pass1_o  (pass1),
        .pass2_o  (pass2),
        .seed_o   (seed),
        .run_o    (run),
        .last_o   (last),
        .bit_o    (bitsel)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [KW-1:0] s_idx;
        assign s_idx = KW'(beats * KW'(j));
        qpp_lane #(.KW(KW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (accept),
            .pass1_i (pass1),
            .pass2_i (pass2),
            .seed_i  (seed),
            .step_i  (run),
            .bit_i   (bitsel),
            .k_i     (k_q),
            .f1_i    (f1_q),
            .f2_i    (f2_q),
            .s_i     (s_idx),
            .addr_o  (addr_o[j*KW +: KW])
        );
    end

    assign valid_o = run;
    assign done_o  = last;
endmodule

// File: rtl/qpp_addr_gen_chk.sv
module qpp_addr_gen_chk #(
    parameter int LANES = 8,
    parameter int KW    = 13
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                valid_o,
    input logic                done_o,
    input logic [LANES*KW-1:0] addr_o,
    input logic [KW-1:0]       k_q
);
    // R4
    done_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> valid_o);

    // R4
    done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !valid_o);

    // R4
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_o) |-> $past(done_o));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && start_i) |=> $stable(k_q));

    for (genvar j = 0; j < LANES; j++) begin : g_rng
        // R6
        addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> (addr_o[j*KW +: KW] < k_q));
    end
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.LANES(LANES), .KW(KW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_o (valid_o),
    .done_o  (done_o),
    .addr_o  (addr_o),
    .k_q     (k_q)
);

// File: tb/qpp_addr_gen_tb.sv
module qpp_addr_gen_tb;
    localparam int LANES = 8;
    localparam int KW    = 13;

    logic                clk = 0;
    logic                rst_n = 0;
    logic                start_i = 0;
    logic [KW-1:0]       k_i = 0, f1_i = 0, f2_i = 0;
    logic                valid_o, done_o;
    logic [LANES*KW-1:0] addr_o;

    int total = 0;
    int bad   = 0;

    logic [LANES*KW:0] exp_q[$];   // {last, addresses}
    int                lane0_log[$];

    always #10 clk = ~clk;

    qpp_addr_gen #(.LANES(LANES), .KW(KW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .k_i(k_i), .f1_i(f1_i), .f2_i(f2_i),
        .valid_o(valid_o), .done_o(done_o), .addr_o(addr_o)
    );

    function automatic int ref_pi(int k, int f1, int f2, int i);
        longint v;
        v = (longint'(f1) * i + longint'(f2) * i * i) % k;
        return int'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // monitor: pops one expected beat per valid cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                logic [LANES*KW:0] e;
                lane0_log.push_back(int'(addr_o[KW-1:0]));
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected valid", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(addr_o == e[LANES*KW-1:0], "R2 lane addresses",
                        longint'(addr_o[KW-1:0]), longint'(e[KW-1:0]));
                    chk(done_o == e[LANES*KW], "R4 done on last beat",
                        longint'(done_o), longint'(e[LANES*KW]));
                end
            end else if (done_o) begin
                chk(0, "R4 done without valid", 1, 0);
            end
        end
    end

    // driver: pushes expected beats, starts a run, optionally injects starts
    task automatic run_block(input int k, input int f1, input int f2, input bit probe);
        int m;
        int n;
        m = k / LANES;
        for (int t = 0; t < m; t++) begin
            logic [LANES*KW:0] e;
            e = '0;
            for (int j = 0; j < LANES; j++)
                e[j*KW +: KW] = KW'(ref_pi(k, f1, f2, j*m + t));
            e[LANES*KW] = (t == m - 1);
            exp_q.push_back(e);
        end
        @(negedge clk);
        k_i = KW'(k); f1_i = KW'(f1); f2_i = KW'(f2);
        start_i = 1;
        n = 0;
        while (n < 100) begin
            @(negedge clk);
            n++;
            if (n == 1) start_i = 0;
            if (probe && n == 4) begin  // R5: start during setup
                start_i = 1; k_i = 13'd72; f1_i = 13'd5; f2_i = 13'd18;
            end
            if (probe && n == 5) start_i = 0;
            if (valid_o) break;
        end
        // R7: first valid after the 28th edge
        chk(n == 2*KW + 2, "R7 setup latency", n, 2*KW + 2);
        if (probe) begin  // R5: start mid-stream
            @(negedge clk);
            start_i = 1; k_i = 13'd40; f1_i = 13'd3; f2_i = 13'd10;
            @(negedge clk);
            start_i = 0;
        end
        n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(!valid_o, "R4 idle after run", valid_o, 0);
        chk(exp_q.size() == 0, "R4 beat count", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lit[5];
        lit = '{0, 13, 6, 19, 12};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!valid_o, "R1 valid in reset", valid_o, 0);
        chk(!done_o, "R1 done in reset", done_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!valid_o && !done_o, "R1 idle after reset", {valid_o, done_o}, 0);

        // R3: literal sequence for K=40
        lane0_log.delete();
        run_block(40, 3, 10, 0);
        for (int t = 0; t < 5; t++)
            chk(lane0_log.size() > t && lane0_log[t] == lit[t], "R3 lane0 sequence",
                (lane0_log.size() > t) ? lane0_log[t] : -1, lit[t]);

        // R5: starts while busy are ignored
        run_block(40, 3, 10, 1);
        run_block(48, 7, 12, 1);

        // R8: other lengths, including the largest
        run_block(256, 15, 32, 0);
        run_block(1024, 31, 64, 1);
        run_block(6144, 263, 480, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule